// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar as packed BCD register bytes: seconds, minutes, hours, day of week, date, month with a century flag, and a two-digit year. It counts a sub-second tick input through a prescaler. Every `TICKS_PER_SEC` ticks the prescaler makes one-second step, and that step ripples through the fields with month-length and leap-year handling. Hours run in either 24-hour or 12-hour form, and the form is chosen by a bit held in the hours byte itself.

Software loads any field through a single-byte write port and reads any field back through a combinational read port. A write to the seconds byte also restarts the prescaler, so the next step comes a full second after that write. The remaining fields must then be loaded inside that second. Values outside the legal ranges give undefined behaviour. The tick is a single-cycle enable, so a simulation can run the clock much faster than real time.

Top module: `bcd_rtc_core`

## Requirements
- R1: Seconds (address 0, bits 6:0) and minutes (address 1, bits 6:0) count in BCD from 00 to 59. The wrap of seconds to 00 carries into minutes, and the wrap of minutes carries into hours.
- R2: With bit 6 of the hours byte (address 2) clear, bits 5:0 count in BCD from 00 to 23. The wrap 23→00 is midnight.
- R3: With bit 6 of the hours byte set, bits 4:0 hold 01–12 in BCD and bit 5 is PM (1 = PM). The sequence runs 11→12, with the PM bit flipping on that step, then 12→01. The step from 11 PM to 12 AM is midnight.
- R4: Day of week (address 3, bits 2:0) steps 1…7→1 at each midnight.
- R5: Date (address 4, bits 5:0) wraps to 01 after the last day of the month. April, June, September and November have 30 days. February has 29 days when the year value is divisible by 4, including 00, and 28 days otherwise. All other months have 31 days.
- R6: Month (address 5, bits 4:0) wraps 12→01 and then increments the year (address 6, 00–99). When the year wraps 99→00, the century flag (bit 7 of address 5) toggles.
- R7: `sec_step_o` pulses in the cycle of every `TICKS_PER_SEC`-th tick, and the fields advance at that clock edge. A write to address 0 clears the prescaler and suppresses any step in that cycle.
- R8: A write in the cycle of a step loads the written field with the write data, and the step still advances all other fields. A carry into the written field is lost.
- R9: After reset the fields read 00 s, 00 min, 00 h in 24-hour mode, day 1, date 01, month 01 with the century flag clear, and year 00.
- R10: Unused bits of every byte read as 0. Address 7 reads 0, and a write to address 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sub-second tick, single-cycle enable |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 3 | Write address (0 sec … 6 year) |
| wr_data_i | input | 8 | Write data byte |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data byte, combinational |
| sec_step_o | output | 1 | One-second step strobe |

## Verification
Two things can land on the same edge: a software write and the one-second step. A write to minutes, hours or a date field is therefore forced in the very cycle the seconds wrap from 59. Random writes at random tick phases add more such collisions. The bench model applies the step first and the write second, and checks after the edge that the written field holds the written byte while the other fields have advanced. A seconds write on the final tick of a second is provoked directly, and the bench checks both that no step occurs and where the next step falls.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [2:0] {
    A_SEC   = 3'd0,
    A_MIN   = 3'd1,
    A_HOUR  = 3'd2,
    A_DOW   = 3'd3,
    A_DATE  = 3'd4,
    A_MONTH = 3'd5,
    A_YEAR  = 3'd6,
    A_NONE  = 3'd7
  } rtc_addr_e;

  localparam int unsigned NUM_FIELDS = 7;

  // year divisible by 4: tens even -> ones 0/4/8, tens odd -> ones 2/6
  function automatic logic leap_year(input logic tens_lsb, input logic [3:0] ones);
    if (tens_lsb) return (ones == 4'd2) || (ones == 4'd6);
    return (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
  endfunction

  function automatic logic [5:0] last_date(input logic [4:0] mon, input logic tens_lsb,
                                           input logic [3:0] ones);
    case (mon)
      5'h02:                      return leap_year(tens_lsb, ones) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

  function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic step_o
);
  generate
    if (DIV <= 1) begin : g_direct
      assign step_o = tick_i && !clr_i;
    end else begin : g_count
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      assign step_o = tick_i && !clr_i && (cnt_q == LAST);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic       wr_sec_i,
  input  logic       wr_min_i,
  input  logic       wr_hour_i,
  input  logic [6:0] wr_data_i,
  output logic [6:0] sec_o,
  output logic [6:0] min_o,
  output logic [6:0] hour_o,
  output logic       day_o
);
  logic [6:0] sec_q, min_q, hour_q;
  logic [6:0] sec_nx, min_nx, hour_nx;
  logic       midnight;
  logic       adv_min, adv_hour;

  always_comb begin
    sec_nx = (sec_q == 7'h59) ? 7'h00 :
             (sec_q[3:0] == 4'd9) ? {sec_q[6:4] + 3'd1, 4'd0} : {sec_q[6:4], sec_q[3:0] + 4'd1};
    min_nx = (min_q == 7'h59) ? 7'h00 :
             (min_q[3:0] == 4'd9) ? {min_q[6:4] + 3'd1, 4'd0} : {min_q[6:4], min_q[3:0] + 4'd1};
    midnight = 1'b0;
    if (hour_q[6]) begin
      if (hour_q[4:0] == 5'h11) begin
        hour_nx  = {1'b1, ~hour_q[5], 5'h12};
        midnight = hour_q[5];
      end else if (hour_q[4:0] == 5'h12) begin
        hour_nx = {hour_q[6:5], 5'h01};
      end else if (hour_q[3:0] == 4'd9) begin
        hour_nx = {hour_q[6:5], 1'b1, 4'd0};
      end else begin
        hour_nx = {hour_q[6:4], hour_q[3:0] + 4'd1};
      end
    end else begin
      if (hour_q[5:0] == 6'h23) begin
        hour_nx  = 7'h00;
        midnight = 1'b1;
      end else if (hour_q[3:0] == 4'd9) begin
        hour_nx = {1'b0, hour_q[5:4] + 2'd1, 4'd0};
      end else begin
        hour_nx = {1'b0, hour_q[5:4], hour_q[3:0] + 4'd1};
      end
    end
  end

  assign adv_min  = step_i && (sec_q == 7'h59);
  assign adv_hour = adv_min && (min_q == 7'h59);
  assign day_o    = adv_hour && midnight;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= 7'h00;
      min_q  <= 7'h00;
      hour_q <= 7'h00;
    end else begin
      if (wr_sec_i)      sec_q <= wr_data_i;
      else if (step_i)   sec_q <= sec_nx;
      if (wr_min_i)      min_q <= wr_data_i;
      else if (adv_min)  min_q <= min_nx;
      if (wr_hour_i)     hour_q <= wr_data_i;
      else if (adv_hour) hour_q <= hour_nx;
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       day_i,
  input  logic       wr_dow_i,
  input  logic       wr_date_i,
  input  logic       wr_month_i,
  input  logic       wr_year_i,
  input  logic [7:0] wr_data_i,
  output logic [2:0] dow_o,
  output logic [5:0] date_o,
  output logic [4:0] month_o,
  output logic       century_o,
  output logic [7:0] year_o
);
  logic [2:0] dow_q;
  logic [5:0] date_q;
  logic [4:0] month_q;
  logic       cent_q;
  logic [7:0] year_q;
  logic       date_last, adv_mon, adv_year;
  logic [5:0] date_nx;
  logic [4:0] month_nx;

  assign date_last = (date_q == last_date(month_q, year_q[4], year_q[3:0]));
  assign adv_mon   = day_i && date_last;
  assign adv_year  = adv_mon && (month_q == 5'h12);

  always_comb begin
    if (date_last)              date_nx = 6'h01;
    else if (date_q[3:0] == 9)  date_nx = {date_q[5:4] + 2'd1, 4'd0};
    else                        date_nx = {date_q[5:4], date_q[3:0] + 4'd1};
    if (month_q == 5'h12)       month_nx = 5'h01;
    else if (month_q[3:0] == 9) month_nx = 5'h10;
    else                        month_nx = {month_q[4], month_q[3:0] + 4'd1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dow_q   <= 3'd1;
      date_q  <= 6'h01;
      month_q <= 5'h01;
      cent_q  <= 1'b0;
      year_q  <= 8'h00;
    end else begin
      if (wr_dow_i)     dow_q <= wr_data_i[2:0];
      else if (day_i)   dow_q <= (dow_q == 3'd7) ? 3'd1 : dow_q + 3'd1;
      if (wr_date_i)    date_q <= wr_data_i[5:0];
      else if (day_i)   date_q <= date_nx;
      if (wr_month_i) begin
        month_q <= wr_data_i[4:0];
        cent_q  <= wr_data_i[7];
      end else if (adv_mon) begin
        month_q <= month_nx;
        if (adv_year && year_q == 8'h99) cent_q <= ~cent_q;
      end
      if (wr_year_i)     year_q <= wr_data_i;
      else if (adv_year) year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc8(year_q);
    end
  end

  assign dow_o     = dow_q;
  assign date_o    = date_q;
  assign month_o   = month_q;
  assign century_o = cent_q;
  assign year_o    = year_q;
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [2:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic       sec_step_o
);
  logic [NUM_FIELDS-1:0] wr_sel;
  logic [6:0] sec_w, min_w, hour_w;
  logic [2:0] dow_w;
  logic [5:0] date_w;
  logic [4:0] mon_w;
  logic       cent_w;
  logic [7:0] year_w;
  logic       day_w;

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_wsel
    assign wr_sel[gi] = wr_en_i && (wr_addr_i == 3'(gi));
  end

  rtc_prescaler #(.DIV(TICKS_PER_SEC)) i_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (wr_sel[A_SEC]),
    .step_o (sec_step_o)
  );

  rtc_time_chain i_time (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (sec_step_o),
    .wr_sec_i  (wr_sel[A_SEC]),
    .wr_min_i  (wr_sel[A_MIN]),
    .wr_hour_i (wr_sel[A_HOUR]),
    .wr_data_i (wr_data_i[6:0]),
    .sec_o     (sec_w),
    .min_o     (min_w),
    .hour_o    (hour_w),
    .day_o     (day_w)
  );

  rtc_date_chain i_date (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .day_i      (day_w),
    .wr_dow_i   (wr_sel[A_DOW]),
    .wr_date_i  (wr_sel[A_DATE]),
    .wr_month_i (wr_sel[A_MONTH]),
    .wr_year_i  (wr_sel[A_YEAR]),
    .wr_data_i  (wr_data_i),
    .dow_o      (dow_w),
    .date_o     (date_w),
    .month_o    (mon_w),
    .century_o  (cent_w),
    .year_o     (year_w)
  );

  always_comb begin
    case (rtc_addr_e'(rd_addr_i))
      A_SEC:   rd_data_o = {1'b0, sec_w};
      A_MIN:   rd_data_o = {1'b0, min_w};
      A_HOUR:  rd_data_o = {1'b0, hour_w};
      A_DOW:   rd_data_o = {5'b0, dow_w};
      A_DATE:  rd_data_o = {2'b0, date_w};
      A_MONTH: rd_data_o = {cent_w, 2'b0, mon_w};
      A_YEAR:  rd_data_o = year_w;
      default: rd_data_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_core_checker.sv
module rtc_core_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       wr_en_i,
  input logic [2:0] wr_addr_i,
  input logic [7:0] wr_data_i,
  input logic       sec_step_o,
  input logic [6:0] sec_v,
  input logic [6:0] hour_v,
  input logic [2:0] dow_v,
  input logic       cent_v,
  input logic [7:0] year_v
);
  assert_sec_bcd_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_v[3:0] <= 4'd9) && (sec_v[6:4] <= 3'd5));

  assert_hour24_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hour_v[6] |-> (hour_v[5:0] <= 6'h23) && (hour_v[3:0] <= 4'd9));

  assert_hour12_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hour_v[6] |-> (hour_v[4:0] >= 5'h01) && (hour_v[4:0] <= 5'h12) && (hour_v[3:0] <= 4'd9));

  assert_dow_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dow_v >= 3'd1) && (dow_v <= 3'd7));

  assert_century_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cent_v != $past(cent_v)) |->
      ($past(wr_en_i && wr_addr_i == 3'd5) || ($past(year_v) == 8'h99 && year_v == 8'h00)));

  assert_step_needs_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_step_o |-> tick_i);

  assert_sec_write_no_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd0) |-> !sec_step_o);

  assert_write_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd0) |=> (sec_v == $past(wr_data_i[6:0])));
endmodule

bind bcd_rtc_core rtc_core_checker i_rtc_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .sec_step_o (sec_step_o),
  .sec_v      (sec_w),
  .hour_v     (hour_w),
  .dow_v      (dow_w),
  .cent_v     (cent_w),
  .year_v     (year_w)
);

// File: tb/test_bcd_rtc_core.sv
`timescale 1ns/1ps
module test_bcd_rtc_core;
  localparam int DIV = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [2:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic       sec_step_o;

  int total = 0;
  int bad = 0;
  int pcnt = 0;
  logic [7:0] mreg [0:6];
  string tag_ovr = "";

  always #2.5 clk_i = ~clk_i;

  bcd_rtc_core #(.TICKS_PER_SEC(DIV)) i_bcd_rtc_core (
    .clk_i, .rst_ni, .tick_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_addr_i, .rd_data_o, .sec_step_o
  );

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return 8'(((v / 10) << 4) + (v % 10));
  endfunction

  function automatic logic [7:0] wmask(input int a);
    case (a)
      0, 1, 2: return 8'h7f;
      3:       return 8'h07;
      4:       return 8'h3f;
      5:       return 8'h9f;
      default: return 8'hff;
    endcase
  endfunction

  function automatic string req_of(input int a);
    case (a)
      0, 1:    return "R1";
      2:       return mreg[2][6] ? "R3" : "R2";
      3:       return "R4";
      4:       return "R5";
      5, 6:    return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic model_second();
    int s, m, hr, dw, d, mo, yr, dim;
    logic pm, midnight;
    logic [7:0] t;
    s = b2i(mreg[0]) + 1;
    if (s < 60) begin mreg[0] = i2b(s); return; end
    mreg[0] = 8'h00;
    m = b2i(mreg[1]) + 1;
    if (m < 60) begin mreg[1] = i2b(m); return; end
    mreg[1] = 8'h00;
    midnight = 1'b0;
    if (mreg[2][6]) begin
      hr = b2i({3'b0, mreg[2][4:0]});
      pm = mreg[2][5];
      if (hr == 11) begin hr = 12; pm = !pm; midnight = !pm; end
      else if (hr == 12) hr = 1;
      else hr = hr + 1;
      t = i2b(hr);
      mreg[2] = {1'b0, 1'b1, pm, t[4:0]};
    end else begin
      hr = b2i({2'b0, mreg[2][5:0]}) + 1;
      if (hr == 24) begin hr = 0; midnight = 1'b1; end
      mreg[2] = i2b(hr);
    end
    if (!midnight) return;
    dw = int'(mreg[3]);
    mreg[3] = (dw == 7) ? 8'd1 : 8'(dw + 1);
    d  = b2i({2'b0, mreg[4][5:0]}) + 1;
    mo = b2i({3'b0, mreg[5][4:0]});
    yr = b2i(mreg[6]);
    if (mo == 2) dim = (yr % 4 == 0) ? 29 : 28;
    else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) dim = 30;
    else dim = 31;
    if (d <= dim) begin mreg[4] = i2b(d); return; end
    mreg[4] = 8'h01;
    mo = mo + 1;
    if (mo <= 12) begin mreg[5] = {mreg[5][7], 2'b0, 5'(i2b(mo))}; return; end
    mreg[5] = {mreg[5][7], 7'h01};
    yr = yr + 1;
    if (yr == 100) begin yr = 0; mreg[5][7] = ~mreg[5][7]; end
    mreg[6] = i2b(yr);
  endtask

  task automatic check_all();
    for (int a = 0; a < 8; a++) begin
      logic [7:0] exp;
      string tg;
      rd_addr_i = 3'(a);
      #0.1;
      exp = (a < 7) ? mreg[a] : 8'h00;
      tg = (tag_ovr != "") ? tag_ovr : req_of(a);
      total++;
      if (rd_data_o !== exp) begin
        bad++;
        $display("FAIL %s addr=%0d actual=%02h expected=%02h", tg, a, rd_data_o, exp);
      end
    end
    tag_ovr = "";
  endtask

  // called at negedge after check_all; returns at next negedge after checking
  task automatic cycle(input logic tk, input logic we, input int a, input logic [7:0] d);
    logic pstep;
    logic sclr;
    tick_i = tk; wr_en_i = we; wr_addr_i = 3'(a); wr_data_i = d;
    sclr  = we && (a == 0);
    pstep = tk && !sclr && (pcnt == DIV - 1);
    #0.3;
    total++;
    if (sec_step_o !== pstep) begin
      bad++;
      $display("FAIL R7 sec_step_o actual=%0b expected=%0b", sec_step_o, pstep);
    end
    @(posedge clk_i);
    if (sclr) pcnt = 0;
    else if (tk) pcnt = (pcnt == DIV - 1) ? 0 : pcnt + 1;
    if (pstep) model_second();
    if (we && a < 7) mreg[a] = d & wmask(a);
    if (we && pstep && a != 0) tag_ovr = "R8";
    if (we && a == 7) tag_ovr = "R10";
    @(negedge clk_i);
    tick_i = 1'b0; wr_en_i = 1'b0;
    check_all();
  endtask

  task automatic preset(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                        input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                        input logic [7:0] y);
    cycle(0, 1, 6, y);
    cycle(0, 1, 5, mo);
    cycle(0, 1, 4, dt);
    cycle(0, 1, 3, dw);
    cycle(0, 1, 2, h);
    cycle(0, 1, 1, m);
    cycle(0, 1, 0, s);
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) cycle(1, 0, 0, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    mreg[0] = 8'h00; mreg[1] = 8'h00; mreg[2] = 8'h00; mreg[3] = 8'h01;
    mreg[4] = 8'h01; mreg[5] = 8'h01; mreg[6] = 8'h00;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    tag_ovr = "R9";
    check_all();

    // R1 basic counting from reset
    run_ticks(3 * DIV);
    // R2 R4 R5 R6: 23:59:59 Sat 31 Dec 99 -> century toggle
    preset(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    run_ticks(DIV + 1);
    // R5 leap Feb 29 in year 24 -> Mar 1
    preset(8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h24);
    run_ticks(DIV + 1);
    // R5 non-leap Feb 28 year 23 -> Mar 1
    preset(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
    run_ticks(DIV + 1);
    // R5 year 00 is leap: Feb 28 -> Feb 29
    preset(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h82, 8'h00);
    run_ticks(DIV + 1);
    // R5 30-day month
    preset(8'h59, 8'h59, 8'h23, 8'h04, 8'h30, 8'h04, 8'h10);
    run_ticks(DIV + 1);
    // R3 11 AM -> 12 PM, 12 PM -> 1 PM, 11 PM -> 12 AM with day advance
    preset(8'h59, 8'h59, 8'h51, 8'h05, 8'h10, 8'h06, 8'h10);
    run_ticks(DIV + 1);
    preset(8'h59, 8'h59, 8'h72, 8'h05, 8'h10, 8'h06, 8'h10);
    run_ticks(DIV + 1);
    preset(8'h59, 8'h59, 8'h71, 8'h05, 8'h30, 8'h06, 8'h10);
    run_ticks(DIV + 1);
    // R8 minute write on the step edge: carry lost, write wins
    preset(8'h59, 8'h10, 8'h08, 8'h01, 8'h05, 8'h03, 8'h20);
    run_ticks(DIV - 1);
    cycle(1, 1, 1, 8'h30);
    // R7 seconds write on the last tick of a second: no step, prescaler restarts
    run_ticks(DIV - 1);
    cycle(1, 1, 0, 8'h20);
    run_ticks(DIV + 1);
    // R10 write to address 7 ignored
    cycle(0, 1, 7, 8'hff);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic tk, we;
      int a;
      logic [7:0] d;
      logic okd;
      tk = ($urandom % 2) == 0;
      we = ($urandom % 12) == 0;
      a  = int'($urandom % 8);
      okd = b2i({2'b0, mreg[4][5:0]}) <= 28;
      case (a)
        0, 1: d = i2b(int'($urandom % 60));
        2: begin
          if ($urandom % 2) begin
            logic [7:0] t;
            t = i2b(1 + int'($urandom % 12));
            d = {1'b0, 1'b1, 1'($urandom % 2), t[4:0]};
          end else d = i2b(int'($urandom % 24));
        end
        3: d = 8'(1 + $urandom % 7);
        4: d = i2b(1 + int'($urandom % 28));
        5: begin d = i2b(1 + int'($urandom % 12)); d[7] = 1'($urandom % 2); we = we && okd; end
        6: begin d = i2b(int'($urandom % 100)); we = we && okd; end
        default: d = 8'($urandom);
      endcase
      cycle(tk, we, a, d);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule